// File: doc/BRIEF.md
# Parallel Mask ROM Read Sequencer

This block sits on the synchronous side of a chip and fetches data from an external asynchronous mask ROM that has a chip-select, an output-enable and a width-select pin. A host presents one read at a time on a valid/ready handshake, with an address and a flag that picks byte or word width. The sequencer drives the ROM address bus and control pins, then waits a number of clock cycles derived from the ROM access times and the clock period. It then latches the data bus and returns the result on a one-cycle response strobe.

In word mode the 23-bit word address goes straight to the ROM pins and all sixteen data lines are returned. In byte mode a 24-bit byte address is split: its upper 23 bits go to the address pins, and its lowest bit is driven onto the top data pin, which the ROM then reads as its lowest address input. Only the low data lane carries data in that mode, so the result is that byte with zeros above it. Between reads the ROM is deselected long enough for its outputs to float again, and for its minimum cycle time to be met.

All cycle counts are ceilings of the timing parameters divided by the clock period. With the defaults (8 ns clock, 100 ns address and select access, 30 ns output-enable access, 20 ns float time, 100 ns cycle) these are an access of AA=13 cycles, an output-enable window of OE=4, a float gap of HZ=3 and a cycle of RC=13.

Top module: `async_rom_reader`

## Requirements
- R1: After reset, and until a request is accepted, `req_ready` is 1, `rom_ce_n` and `rom_oe_n` are 1, `rsp_valid` is 0 and `rom_lsb_oe` is 0.
- R2: A word request (`req_byte`=0) drives `rom_addr` = `req_addr[22:0]`, with `req_addr[23]` ignored. It sets `rom_byte_n`=1 and `rom_lsb_oe`=0, and the address stays unchanged while `rom_ce_n` is low.
- R3: A byte request (`req_byte`=1) drives `rom_addr` = `req_addr[23:1]`, `rom_byte_n`=0, `rom_lsb_oe`=1 and `rom_lsb_out` = `req_addr[0]`. The width select stays unchanged while `rom_ce_n` is low.
- R4: `rom_ce_n` falls on the clock edge that accepts a request. `rom_oe_n` is low only while `rom_ce_n` is low.
- R5: The data bus is sampled on the AA-th clock edge after the accepting edge. That edge is at least the address/select access time after the address and select were applied, and at least the output-enable access time after `rom_oe_n` fell. On the same edge `rsp_valid` rises for exactly one cycle, and `rom_ce_n` and `rom_oe_n` return high.
- R6: A word response returns all sixteen lines `rom_dq_in[15:0]` unchanged.
- R7: A byte response returns `{8'h00, rom_dq_in[7:0]}`. Lines 15 to 8 have no effect, whatever values they float to.
- R8: Between two reads, `rom_ce_n` stays high for at least HZ cycles, and successive select assertions are at least the cycle time apart. With requests waiting back to back, accepts are exactly max(AA+max(HZ,1), RC)+1 cycles apart, which is 17 with the defaults.
- R9: `req_ready` is 1 only while the ROM is deselected and idle, so no request is accepted between an accept and the end of its recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_addr | input | 24 | Byte address (byte mode) or word address in bits 22:0 (word mode) |
| req_byte | input | 1 | 1 selects byte width, 0 word width |
| rsp_valid | output | 1 | One-cycle strobe with read data |
| rsp_data | output | 16 | Read result, zero-extended in byte mode |
| rom_addr | output | 23 | ROM address pins |
| rom_ce_n | output | 1 | ROM chip select, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_byte_n | output | 1 | ROM width select, low for byte width |
| rom_lsb_out | output | 1 | Value driven onto the top data pin as lowest byte address bit |
| rom_lsb_oe | output | 1 | Output enable for the top data pin |
| rom_dq_in | input | 16 | ROM data bus as seen by the sequencer |

## Verification
The properties assume that reset is held for at least one clock edge and that the host changes requests only between clock edges. They also assume that the float-gap count fits the checker's saturating 8-bit run counter. The bench drives requests only at falling edges and drops `req_valid` right after each accept, except in the back-to-back run. It models the ROM with a time-stamped behavioural memory that puts a corrupt pattern on the bus whenever any access time is not yet met when the next edge comes. A sample taken one edge too early therefore shows up as a data mismatch rather than going unseen.

// File: rtl/async_rom_reader.sv
module async_rom_reader #(
  parameter int WA_W     = 23,
  parameter int DQ_W     = 16,
  parameter int CLK_PS   = 8000,
  parameter int T_ACC_PS = 100000,
  parameter int T_OE_PS  = 30000,
  parameter int T_HZ_PS  = 20000,
  parameter int T_RC_PS  = 100000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [WA_W:0]   req_addr,
  input  logic            req_byte,
  output logic            rsp_valid,
  output logic [DQ_W-1:0] rsp_data,
  output logic [WA_W-1:0] rom_addr,
  output logic            rom_ce_n,
  output logic            rom_oe_n,
  output logic            rom_byte_n,
  output logic            rom_lsb_out,
  output logic            rom_lsb_oe,
  input  logic [DQ_W-1:0] rom_dq_in
);
  localparam int AA_CYC   = (T_ACC_PS + CLK_PS - 1) / CLK_PS;
  localparam int OE_CYC   = (T_OE_PS + CLK_PS - 1) / CLK_PS;
  localparam int HZ_CYC   = (T_HZ_PS + CLK_PS - 1) / CLK_PS;
  localparam int RC_CYC   = (T_RC_PS + CLK_PS - 1) / CLK_PS;
  localparam int OE_START = (AA_CYC > OE_CYC) ? AA_CYC - OE_CYC : 0;
  localparam int CNT_W    = $clog2(AA_CYC + RC_CYC + HZ_CYC + 2);
  localparam int HALF     = DQ_W / 2;

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_REC} st_t;
  st_t state;

  logic             byte_q, lsb_q;
  logic [CNT_W-1:0] cyc, ocnt, hcnt;

  assign req_ready   = (state == S_IDLE);
  assign rom_lsb_oe  = byte_q;
  assign rom_lsb_out = lsb_q & byte_q;

  wire accept   = req_valid && req_ready;
  wire acc_done = ((cyc + 1'b1) >= CNT_W'(AA_CYC)) && !rom_oe_n &&
                  ((ocnt + 1'b1) >= CNT_W'(OE_CYC));
  wire rec_done = ((hcnt + 1'b1) >= CNT_W'(HZ_CYC)) &&
                  ((cyc + 1'b1) >= CNT_W'(RC_CYC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      rom_ce_n   <= 1'b1;
      rom_oe_n   <= 1'b1;
      rom_byte_n <= 1'b1;
      rom_addr   <= '0;
      byte_q     <= 1'b0;
      lsb_q      <= 1'b0;
      cyc        <= '0;
      ocnt       <= '0;
      hcnt       <= '0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        S_IDLE: if (accept) begin
          byte_q     <= req_byte;
          rom_byte_n <= !req_byte;
          rom_addr   <= req_byte ? req_addr[WA_W:1] : req_addr[WA_W-1:0];
          lsb_q      <= req_addr[0];
          rom_ce_n   <= 1'b0;
          rom_oe_n   <= (OE_START == 0) ? 1'b0 : 1'b1;
          cyc        <= '0;
          ocnt       <= '0;
          state      <= S_ACC;
        end
        S_ACC: begin
          cyc <= cyc + 1'b1;
          if (acc_done) begin
            rsp_valid <= 1'b1;
            rsp_data  <= byte_q ? {{HALF{1'b0}}, rom_dq_in[HALF-1:0]} : rom_dq_in;
            rom_ce_n  <= 1'b1;
            rom_oe_n  <= 1'b1;
            hcnt      <= '0;
            state     <= S_REC;
          end else if (rom_oe_n && (cyc + 1'b1) == CNT_W'(OE_START)) begin
            rom_oe_n <= 1'b0;
            ocnt     <= '0;
          end else if (!rom_oe_n) begin
            ocnt <= ocnt + 1'b1;
          end
        end
        S_REC: begin
          cyc  <= cyc + 1'b1;
          hcnt <= hcnt + 1'b1;
          if (rec_done) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/async_rom_reader_chk.sv
module async_rom_reader_chk #(
  parameter int WA_W   = 23,
  parameter int HZ_CYC = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rom_ce_n,
  input logic            rom_oe_n,
  input logic            rom_byte_n,
  input logic [WA_W-1:0] rom_addr
);
  logic [7:0] hz_run;

  always_ff @(posedge clk) begin
    if (!rst_n)           hz_run <= 8'hFF;
    else if (!rom_ce_n)   hz_run <= 8'h00;
    else if (hz_run != 8'hFF) hz_run <= hz_run + 8'h01;
  end

  p_oe_within_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> !rom_ce_n);

  p_rsp_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_ce_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> (rom_ce_n && rom_oe_n && $past(!rom_ce_n)));

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_ce_n && $past(!rom_ce_n)) |-> $stable(rom_addr));

  p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_ce_n && $past(!rom_ce_n)) |-> $stable(rom_byte_n));

  p_idle_only_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (rom_ce_n && rom_oe_n && !rsp_valid));

  p_hz_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_ce_n) |-> (hz_run >= 8'(HZ_CYC)));
endmodule

bind async_rom_reader async_rom_reader_chk #(.WA_W(WA_W), .HZ_CYC(HZ_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_byte_n(rom_byte_n),
  .rom_addr(rom_addr)
);

// File: tb/async_rom_reader_bench.sv
`timescale 1ns/1ps
module async_rom_reader_bench;
  localparam int CLK_NS = 8;
  localparam int TACC = 100, TOE = 30, THZ = 20, TRC = 100;
  localparam int AA = (TACC + CLK_NS - 1) / CLK_NS;
  localparam int HZ = (THZ + CLK_NS - 1) / CLK_NS;
  localparam int RC = (TRC + CLK_NS - 1) / CLK_NS;
  localparam int HZ1 = (HZ > 1) ? HZ : 1;
  localparam int GAP = ((AA + HZ1) > RC ? (AA + HZ1) : RC) + 1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_byte = 0;
  logic [23:0] req_addr = '0;
  logic req_ready, rsp_valid, rom_ce_n, rom_oe_n, rom_byte_n, rom_lsb_out, rom_lsb_oe;
  logic [15:0] rsp_data;
  logic [22:0] rom_addr;
  logic [15:0] rom_dq_in = 16'h5A5A;

  int n_tests = 0, n_fail = 0, ncyc = 0;
  bit done = 0;
  time t_addr = 0, t_ce_fall = 0, t_ce_rise = 0, t_oe_fall = 0;
  bit had_read = 0;

  always #(CLK_NS/2) clk = ~clk;
  always @(negedge clk) ncyc++;

  async_rom_reader u_async_rom_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_byte(req_byte), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rom_addr(rom_addr), .rom_ce_n(rom_ce_n),
    .rom_oe_n(rom_oe_n), .rom_byte_n(rom_byte_n), .rom_lsb_out(rom_lsb_out),
    .rom_lsb_oe(rom_lsb_oe), .rom_dq_in(rom_dq_in)
  );

  function automatic logic [15:0] wfun(input logic [22:0] w);
    return w[15:0] ^ {w[22:16], 9'h0} ^ {w[7:0], w[15:8]} ^ 16'h3C96;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(rom_addr or rom_byte_n or rom_lsb_out) t_addr = $time;
  always @(posedge rom_ce_n) t_ce_rise = $time;
  always @(negedge rom_oe_n) t_oe_fall = $time;
  always @(negedge rom_ce_n) begin
    if (had_read) begin
      chk(($time - t_ce_rise) >= THZ, "R8 float gap ns", $time - t_ce_rise, THZ);
      chk(($time - t_ce_fall) >= TRC, "R8 cycle time ns", $time - t_ce_fall, TRC);
    end
    had_read = 1;
    t_ce_fall = $time;
  end

  initial begin
    forever begin
      @(posedge clk);
      #(CLK_NS - 1);
      if (rom_ce_n || rom_oe_n) rom_dq_in = 16'h5A5A;
      else if (($time + 1 - t_addr) < TACC || ($time + 1 - t_ce_fall) < TACC ||
               ($time + 1 - t_oe_fall) < TOE) rom_dq_in = 16'hE11E;
      else if (!rom_byte_n) begin
        logic [15:0] w;
        w = wfun(rom_addr);
        rom_dq_in = {1'b1, 7'h55, rom_lsb_out ? w[15:8] : w[7:0]};
      end else rom_dq_in = wfun(rom_addr);
    end
  end

  task automatic do_read(input logic [23:0] a, input bit byt);
    int n;
    bit busy_ok;
    logic [15:0] w, exp;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_byte = byt;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(!rom_ce_n, "R4 select on accept", rom_ce_n, 0);
    if (byt) begin
      chk(rom_addr == a[23:1], "R3 byte address pins", rom_addr, a[23:1]);
      chk({rom_byte_n, rom_lsb_oe, rom_lsb_out} == {1'b0, 1'b1, a[0]},
          "R3 width pin and lsb pin", {rom_byte_n, rom_lsb_oe, rom_lsb_out}, {1'b0, 1'b1, a[0]});
    end else begin
      chk(rom_addr == a[22:0], "R2 word address pins", rom_addr, a[22:0]);
      chk({rom_byte_n, rom_lsb_oe} == 2'b10, "R2 width pin and lsb pin",
          {rom_byte_n, rom_lsb_oe}, 2'b10);
    end
    n = 0; busy_ok = !req_ready;
    while (!rsp_valid && n < 100) begin
      @(negedge clk); n++;
      if (req_ready) busy_ok = 0;
    end
    chk(n == AA, "R5 sample latency cycles", n, AA);
    chk(busy_ok, "R9 ready low while busy", busy_ok, 1);
    w = wfun(byt ? a[23:1] : a[22:0]);
    exp = byt ? {8'h00, a[0] ? w[15:8] : w[7:0]} : w;
    chk(rsp_data == exp, byt ? "R7 byte result" : "R6 word result", rsp_data, exp);
    chk(rom_ce_n && rom_oe_n, "R5 release after sample", {rom_ce_n, rom_oe_n}, 2'b11);
    @(negedge clk);
    chk(!rsp_valid, "R5 single strobe", rsp_valid, 0);
  endtask

  initial begin
    #(200000 * CLK_NS);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && rom_ce_n && rom_oe_n && !rsp_valid && !rom_lsb_oe,
        "R1 reset state", {req_ready, rom_ce_n, rom_oe_n, rsp_valid, rom_lsb_oe}, 5'b11100);

    do_read(24'h000000, 0);
    do_read(24'hFFFFFF, 0);
    do_read(24'h7FFFFF, 0);
    for (int i = 0; i < 23; i++) do_read(24'h800000 | (24'h1 << i), 0);
    do_read(24'h000000, 1);
    do_read(24'hFFFFFF, 1);
    do_read(24'h000100, 1);
    do_read(24'h000101, 1);
    for (int i = 0; i < 24; i++) do_read(24'h1 << i, 1);
    for (int i = 0; i < 16; i++) do_read(24'hA53C00 + 24'(i * 37), i[0]);

    begin
      int last = 0;
      @(negedge clk);
      req_valid = 1;
      for (int k = 0; k < 5; k++) begin
        req_addr = 24'h123456 + 24'(k * 3); req_byte = k[0];
        while (!req_ready) @(negedge clk);
        if (k > 0) chk((ncyc - last) == GAP, "R8 back-to-back interval", ncyc - last, GAP);
        last = ncyc;
        @(negedge clk);
      end
      req_valid = 0;
      repeat (GAP + 2) @(negedge clk);
      chk(req_ready && rom_ce_n, "R9 idle after run", {req_ready, rom_ce_n}, 2'b11);
    end

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule